// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps the coherence state of a small direct-mapped private cache that uses write-back. It sits on an atomic snooping bus. Every line is tracked as Invalid, Shared or Modified. The processor holds a read or write request, with a line address, until the controller raises `cpu_ready` for one cycle. While a request waits, the controller may place commands on the bus. It sends a writeback of a dirty victim, a shared-read request, or an exclusive-read request. When a local upgrade leaves memory's data unused, it marks the exclusive-read as an upgrade.

The controller also watches the reads and exclusive reads that other caches issue. When its own copy is dirty, it answers in the same cycle with a flush. In that same cycle it demotes or invalidates its copy. A bus command completes in the cycle where `bus_grant` is high while `bus_req_valid` is high. The external arbiter never grants this cache in a cycle that carries a snoop.

Only tags and states are held here. The data array sits outside the block. Snoops always take priority: a local request whose index matches the snooped index waits that cycle. On the next cycle it is decided again against the updated state.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 2'b00), so the first read of any address issues a shared-read request and is not acknowledged until granted.
- R2: A read that misses issues bus command 2'b01 (shared read) with the request address. On grant, `cpu_ready` is high in that same cycle and the line becomes Shared (code 2'b01).
- R3: A write that misses issues bus command 2'b10 (exclusive read) with `bus_req_upg` low. On grant the line becomes Modified (code 2'b10).
- R4: A write to a Shared line issues command 2'b10 with `bus_req_upg` high, which tells memory that no data is needed. On grant the line becomes Modified.
- R5: Reads that hit a Shared or Modified line, and writes that hit a Modified line, raise `cpu_ready` in the same cycle with `bus_req_valid` low.
- R6: A snooped shared read (snoop command 2'b01) that hits a Modified line raises `snp_flush` in that cycle, and the line becomes Shared.
- R7: A snooped exclusive read (snoop command 2'b10) that hits a Modified line raises `snp_flush`, and the line becomes Invalid.
- R8: A snooped exclusive read that hits a Shared line invalidates it without a flush. A snooped shared read leaves a Shared line Shared without a flush, and snoops that miss change nothing.
- R9: A miss whose victim line is Modified first issues command 2'b11 (writeback) carrying the victim's line address, with `cpu_ready` low. Only after that grant does it issue the fill request. A Shared victim is dropped silently.
- R10: In a cycle where the snoop index equals the local request index, the local request issues nothing and is not acknowledged. On the next cycle it is decided against the state the snoop left.
- R11: Line address bits [IDX_W-1:0] select the entry, and the rest form the tag. `bus_req_cmd` is 2'b00 whenever `bus_req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request pending, held until acknowledged |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_ready | output | 1 | Request completes this cycle (low = stall) |
| bus_req_valid | output | 1 | Controller drives a bus command |
| bus_req_cmd | output | 2 | 00 none, 01 shared read, 10 exclusive read, 11 writeback |
| bus_req_upg | output | 1 | Exclusive read is an upgrade; memory data not needed |
| bus_req_addr | output | ADDR_W | Line address of the bus command |
| bus_grant | input | 1 | Bus command completes this cycle |
| snp_valid | input | 1 | Another cache's command is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_flush | output | 1 | This cache supplies dirty data for the snoop |

## Verification
The bench drives one line through every state and then checks its state at the ports. Three things reveal the state: whether a later write issues an upgrade, a full exclusive read or nothing, and whether a later snooped read draws a flush. If a controller forgot to demote on a snooped read, it would flush twice. If it failed to invalidate a Shared line on a snooped exclusive read, it would later hit on stale data and issue no bus command.

The bench forces an eviction of a dirty line and checks that the writeback carries the old tag and comes before the fill. It also checks that a clean victim goes straight to the fill. A snoop is made to collide with a pending upgrade. A design that did not re-decide after the snoop would still send the upgrade flag even though the line is gone.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_M = 2'b10
    } lstate_t;

    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_RD   = 2'b01,
        CMD_RDX  = 2'b10,
        CMD_WB   = 2'b11
    } bcmd_t;

    typedef struct packed {
        lstate_t nxt;
        logic    flush;
        logic    touch;
    } snp_resp_t;

    // Reaction of a resident line to a command seen on the bus.
    function automatic snp_resp_t snoop_react(lstate_t cur, bcmd_t cmd);
        snp_resp_t r;
        r.nxt   = cur;
        r.flush = 1'b0;
        r.touch = 1'b0;
        case (cur)
            ST_M: begin
                if (cmd == CMD_RD) begin
                    r.nxt = ST_S; r.flush = 1'b1; r.touch = 1'b1;
                end else if (cmd == CMD_RDX) begin
                    r.nxt = ST_I; r.flush = 1'b1; r.touch = 1'b1;
                end
            end
            ST_S: begin
                if (cmd == CMD_RDX) begin
                    r.nxt = ST_I; r.touch = 1'b1;
                end
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic lstate_t fill_state(logic is_write);
        return is_write ? ST_M : ST_S;
    endfunction

endpackage

// File: rtl/msi_tag_store.sv
module msi_tag_store
    import msi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] a_idx,
    output logic [TAG_W-1:0] a_tag,
    output lstate_t          a_st,
    input  logic [IDX_W-1:0] b_idx,
    output logic [TAG_W-1:0] b_tag,
    output lstate_t          b_st,
    input  logic             wa_en,
    input  logic [IDX_W-1:0] wa_idx,
    input  logic [TAG_W-1:0] wa_tag,
    input  lstate_t          wa_st,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [TAG_W-1:0] wb_tag,
    input  lstate_t          wb_st
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tags [LINES];
    lstate_t          sts  [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                tags[i] <= '0;
                sts[i]  <= ST_I;
            end else if (wa_en && wa_idx == IDX_W'(i)) begin
                tags[i] <= wa_tag;
                sts[i]  <= wa_st;
            end else if (wb_en && wb_idx == IDX_W'(i)) begin
                tags[i] <= wb_tag;
                sts[i]  <= wb_st;
            end
        end
    end

    assign a_tag = tags[a_idx];
    assign a_st  = sts[a_idx];
    assign b_tag = tags[b_idx];
    assign b_st  = sts[b_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic             snp_valid,
    input  bcmd_t            snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] lk_tag,
    input  lstate_t          lk_st,
    output logic             flush,
    output logic             wr_en,
    output lstate_t          wr_st
);
    logic      hit;
    snp_resp_t resp;

    always_comb begin
        hit   = snp_valid && (lk_st != ST_I) && (lk_tag == snp_tag);
        resp  = snoop_react(lk_st, snp_cmd);
        flush = hit && resp.flush;
        wr_en = hit && resp.touch;
        wr_st = resp.nxt;
    end

endmodule

// File: rtl/msi_req_unit.sv
module msi_req_unit
    import msi_pkg::*;
#(
    parameter int TAG_W = 13
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             collide,
    input  logic             grant,
    input  logic [TAG_W-1:0] lk_tag,
    input  lstate_t          lk_st,
    output logic             ready,
    output logic             bus_valid,
    output bcmd_t            bus_cmd,
    output logic             bus_upg,
    output logic [TAG_W-1:0] bus_tag,
    output logic             wr_en,
    output logic [TAG_W-1:0] wr_tag,
    output lstate_t          wr_st
);
    logic tag_match, hit, go;

    always_comb begin
        tag_match = (lk_st != ST_I) && (lk_tag == req_tag);
        hit       = tag_match && (!req_write || lk_st == ST_M);
        go        = req_valid && !collide;

        ready     = 1'b0;
        bus_valid = 1'b0;
        bus_cmd   = CMD_NONE;
        bus_upg   = 1'b0;
        bus_tag   = req_tag;
        wr_en     = 1'b0;
        wr_tag    = req_tag;
        wr_st     = ST_I;

        if (go) begin
            if (hit) begin
                ready = 1'b1;
            end else if (!tag_match && lk_st == ST_M) begin
                // dirty victim leaves first
                bus_valid = 1'b1;
                bus_cmd   = CMD_WB;
                bus_tag   = lk_tag;
                wr_en     = grant;
                wr_tag    = lk_tag;
                wr_st     = ST_I;
            end else begin
                bus_valid = 1'b1;
                bus_cmd   = req_write ? CMD_RDX : CMD_RD;
                bus_upg   = req_write && tag_match;
                wr_en     = grant;
                wr_st     = fill_state(req_write);
                ready     = grant;
            end
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_ready,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic              bus_req_upg,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_grant,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_flush
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] req_idx, snp_idx;
    logic [TAG_W-1:0] req_tag, snp_tag;
    logic [TAG_W-1:0] lr_tag, ls_tag;
    lstate_t          lr_st, ls_st;

    logic             s_wr_en;
    lstate_t          s_wr_st;
    logic             r_wr_en;
    logic [TAG_W-1:0] r_wr_tag;
    lstate_t          r_wr_st;
    bcmd_t            r_cmd;
    logic [TAG_W-1:0] r_bus_tag;
    logic             collide;

    assign req_idx = cpu_req_addr[IDX_W-1:0];
    assign req_tag = cpu_req_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
    assign collide = snp_valid && (snp_idx == req_idx);

    msi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .a_idx  (snp_idx),
        .a_tag  (ls_tag),
        .a_st   (ls_st),
        .b_idx  (req_idx),
        .b_tag  (lr_tag),
        .b_st   (lr_st),
        .wa_en  (s_wr_en),
        .wa_idx (snp_idx),
        .wa_tag (ls_tag),
        .wa_st  (s_wr_st),
        .wb_en  (r_wr_en),
        .wb_idx (req_idx),
        .wb_tag (r_wr_tag),
        .wb_st  (r_wr_st)
    );

    msi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (bcmd_t'(snp_cmd)),
        .snp_tag   (snp_tag),
        .lk_tag    (ls_tag),
        .lk_st     (ls_st),
        .flush     (snp_flush),
        .wr_en     (s_wr_en),
        .wr_st     (s_wr_st)
    );

    msi_req_unit #(.TAG_W(TAG_W)) u_req (
        .req_valid (cpu_req_valid),
        .req_write (cpu_req_write),
        .req_tag   (req_tag),
        .collide   (collide),
        .grant     (bus_grant),
        .lk_tag    (lr_tag),
        .lk_st     (lr_st),
        .ready     (cpu_ready),
        .bus_valid (bus_req_valid),
        .bus_cmd   (r_cmd),
        .bus_upg   (bus_req_upg),
        .bus_tag   (r_bus_tag),
        .wr_en     (r_wr_en),
        .wr_tag    (r_wr_tag),
        .wr_st     (r_wr_st)
    );

    assign bus_req_cmd  = r_cmd;
    assign bus_req_addr = {r_bus_tag, req_idx};

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req_valid,
    input logic              cpu_req_write,
    input logic [ADDR_W-1:0] cpu_req_addr,
    input logic              cpu_ready,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_cmd,
    input logic              bus_req_upg,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_grant,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_flush
);
    p_flush_needs_snoop_r6: assert property (@(posedge clk) disable iff (rst)
        snp_flush |-> snp_valid);

    p_upgrade_is_rdx_r4: assert property (@(posedge clk) disable iff (rst)
        bus_req_upg |-> (bus_req_valid && bus_req_cmd == 2'b10 && cpu_req_write));

    p_wb_holds_cpu_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_req_cmd == 2'b11) |-> !cpu_ready);

    p_collide_blocks_r10: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && cpu_req_valid && snp_addr[IDX_W-1:0] == cpu_req_addr[IDX_W-1:0])
            |-> (!bus_req_valid && !cpu_ready));

    p_idle_cmd_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_req_valid |-> bus_req_cmd == 2'b00);

    p_ready_via_grant_r2: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && bus_req_valid) |-> bus_grant);

    p_rdx_kills_r7: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_cmd == 2'b10) |=>
            !(snp_valid && snp_flush && snp_addr == $past(snp_addr)));

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/sim_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_msi_snoop_ctrl;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_req_valid, cpu_req_write;
    logic [AW-1:0] cpu_req_addr;
    logic          cpu_ready;
    logic          bus_req_valid;
    logic [1:0]    bus_req_cmd;
    logic          bus_req_upg;
    logic [AW-1:0] bus_req_addr;
    logic          bus_grant;
    logic          snp_valid;
    logic [1:0]    snp_cmd;
    logic [AW-1:0] snp_addr;
    logic          snp_flush;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(3)) u0 (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // drive inputs just after a falling edge and let them settle
    task automatic drive(logic v, logic w, logic [AW-1:0] a, logic g,
                         logic sv, logic [1:0] sc, logic [AW-1:0] sa);
        cpu_req_valid = v; cpu_req_write = w; cpu_req_addr = a;
        bus_grant = g; snp_valid = sv; snp_cmd = sc; snp_addr = sa;
        #4;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        drive(0, 0, '0, 0, 0, 2'b00, '0);
        step();
    endtask

    // request observed ungranted, then granted
    task automatic miss(string tag, logic w, logic [AW-1:0] a,
                        logic [1:0] exp_cmd, logic exp_upg);
        drive(1, w, a, 0, 0, 2'b00, '0);
        chk({tag, " valid"}, bus_req_valid, 1);
        chk({tag, " cmd"}, bus_req_cmd, exp_cmd);
        chk({tag, " upg"}, bus_req_upg, exp_upg);
        chk({tag, " addr"}, bus_req_addr, a);
        chk({tag, " stall"}, cpu_ready, 0);
        step();
        drive(1, w, a, 1, 0, 2'b00, '0);
        chk({tag, " ready on grant"}, cpu_ready, 1);
        step();
        idle();
    endtask

    task automatic hit(string tag, logic w, logic [AW-1:0] a);
        drive(1, w, a, 0, 0, 2'b00, '0);
        chk({tag, " ready"}, cpu_ready, 1);
        chk({tag, " no bus"}, bus_req_valid, 0);
        step();
        idle();
    endtask

    task automatic snoop(string tag, logic [1:0] c, logic [AW-1:0] a, logic exp_fl);
        drive(0, 0, '0, 0, 1, c, a);
        chk({tag, " flush"}, snp_flush, exp_fl);
        step();
        idle();
    endtask

    task automatic t_reset_and_read();
        miss("R1 R2 first read", 0, 16'h0010, 2'b01, 0);
        hit("R5 read hit S", 0, 16'h0010);
        chk("R11 idle cmd", bus_req_cmd, 2'b00);
    endtask

    task automatic t_upgrade();
        miss("R4 upgrade", 1, 16'h0010, 2'b10, 1);
        hit("R5 write hit M", 1, 16'h0010);
        hit("R5 read hit M", 0, 16'h0010);
    endtask

    task automatic t_snoop_m();
        snoop("R6 BusRd on M", 2'b01, 16'h0010, 1);
        snoop("R8 BusRd on S", 2'b01, 16'h0010, 0);
        miss("R4 re-upgrade", 1, 16'h0010, 2'b10, 1);
        snoop("R7 BusRdX on M", 2'b10, 16'h0010, 1);
        miss("R7 line invalid", 0, 16'h0010, 2'b01, 0);
    endtask

    task automatic t_write_miss();
        miss("R3 write miss", 1, 16'h0021, 2'b10, 0);
        snoop("R3 now M", 2'b01, 16'h0021, 1);
    endtask

    task automatic t_evict();
        miss("R9 setup", 1, 16'h0032, 2'b10, 0);
        drive(1, 0, 16'h0042, 0, 0, 2'b00, '0);
        chk("R9 wb cmd", bus_req_cmd, 2'b11);
        chk("R9 wb addr", bus_req_addr, 16'h0032);
        chk("R9 wb stall", cpu_ready, 0);
        step();
        drive(1, 0, 16'h0042, 1, 0, 2'b00, '0);
        chk("R9 wb granted stall", cpu_ready, 0);
        step();
        drive(1, 0, 16'h0042, 0, 0, 2'b00, '0);
        chk("R9 fill after wb", bus_req_cmd, 2'b01);
        chk("R9 fill addr", bus_req_addr, 16'h0042);
        step();
        drive(1, 0, 16'h0042, 1, 0, 2'b00, '0);
        chk("R9 fill ready", cpu_ready, 1);
        step();
        idle();
        snoop("R9 victim gone", 2'b01, 16'h0032, 0);
        miss("R9 clean victim silent", 0, 16'h0052, 2'b01, 0);
    endtask

    task automatic t_snoop_s();
        snoop("R8 miss snoop other tag", 2'b10, 16'h0042, 0);
        hit("R8 unaffected", 0, 16'h0052);
        snoop("R8 BusRdX on S", 2'b10, 16'h0052, 0);
        miss("R8 S invalidated", 0, 16'h0052, 2'b01, 0);
    endtask

    task automatic t_collide();
        miss("R10 setup", 0, 16'h0063, 2'b01, 0);
        drive(1, 1, 16'h0063, 1, 1, 2'b10, 16'h0063);
        chk("R10 no bus on collide", bus_req_valid, 0);
        chk("R10 no ready on collide", cpu_ready, 0);
        chk("R10 no flush for S", snp_flush, 0);
        step();
        drive(1, 1, 16'h0063, 0, 0, 2'b00, '0);
        chk("R10 re-decided cmd", bus_req_cmd, 2'b10);
        chk("R10 re-decided no upg", bus_req_upg, 0);
        step();
        drive(1, 1, 16'h0064, 0, 1, 2'b01, 16'h0065);
        chk("R11 other index proceeds", bus_req_valid, 1);
        chk("R11 index field", bus_req_addr, 16'h0064);
        step();
        idle();
    endtask

    initial begin
        rst = 1'b1;
        drive(0, 0, '0, 0, 0, 2'b00, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle();
        chk("R1 reset no bus", bus_req_valid, 0);
        chk("R1 reset no flush", snp_flush, 0);
        t_reset_and_read();
        t_upgrade();
        t_snoop_m();
        t_write_miss();
        t_evict();
        t_snoop_s();
        t_collide();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule